// File: doc/BRIEF.md
# Jump and Interrupt Redirect Control

This block sits beside the fetch stage of a small 8-bit pipelined core. Every cycle it looks at the decoded jump operation, the jump target, the four execution flags, a single interrupt request and the current program address. From these it decides whether fetch must redirect, and to which address. Conditional jumps test the carry or zero flag. An unconditional jump always redirects.

An interrupt sends fetch to a fixed vector at 0xF0. At that point the block stores the current address and the flags in a one-deep context. A later return instruction redirects back to the stored address and presents the stored flags so the execute stage can reload them. The context has a single slot. While it holds an unreturned interrupt, further interrupt requests are ignored.

Top module: `jump_irq_ctrl`

## Requirements
- R1: Operation codes on `jump_op_i` are 0 none, 1 unconditional jump, 2 jump if carry, 3 jump if no carry, 4 jump if zero, 5 jump if not zero, 6 return. Flag bit 0 is carry, bit 1 zero, bit 2 overflow, bit 3 parity. A conditional jump whose condition holds sets `redirect_o` to 1 and `jump_loc_o` to `jump_target_i` in the same cycle.
- R2: A conditional jump whose condition fails leaves `redirect_o` at 0. Overflow and parity have no effect on any condition.
- R3: An unconditional jump always redirects to `jump_target_i`. Operation 0 never redirects.
- R4: An interrupt request while no interrupt is in service is accepted. In the same cycle it sets `redirect_o` to 1 and `jump_loc_o` to 0xF0, and it overrides any jump operation present in that cycle.
- R5: On the rising edge that accepts an interrupt, `pc_i` and `flags_i` are stored. The stored values do not change until a return executes.
- R6: An interrupt request while an earlier interrupt is in service has no effect. Redirection then follows `jump_op_i` alone.
- R7: A return sets `redirect_o` to 1, sets `jump_loc_o` to the stored address, sets `restore_o` to 1 and drives the stored flags on `flags_restored_o`. It ends the in-service state, so the next interrupt is accepted.
- R8: Reset (`rst_ni` low) clears the stored address, the stored flags and the in-service state. A return right after reset therefore targets 0x00 with flags 0x0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| jump_op_i | input | 3 | Decoded jump operation (encoding in R1) |
| jump_target_i | input | 8 | Target address for jumps |
| flags_i | input | 4 | Execution flags {parity, overflow, zero, carry} |
| irq_i | input | 1 | Interrupt request |
| pc_i | input | 8 | Current program address |
| redirect_o | output | 1 | Fetch must load `jump_loc_o` |
| jump_loc_o | output | 8 | Redirect address |
| restore_o | output | 1 | Return in progress, flags to reload |
| flags_restored_o | output | 4 | Stored flags for reload |

## Verification
`redirect_o`, `jump_loc_o`, `restore_o` and `flags_restored_o` are combinational, so each result is due in the same cycle as its stimulus. The bench drives inputs on the falling edge and checks the outputs 1 ns later, before the next rising edge. The stored context and the in-service state change on the rising edge that ends that cycle. Checks that depend on them (ignored interrupts, return targets, restored flags) are therefore made in a later cycle, after at least one rising edge has passed.

// File: rtl/jic_pkg.sv
package jic_pkg;
  localparam int ADDR_W = 8;
  localparam int FLAG_W = 4;
  localparam int OP_W   = 3;
  localparam logic [ADDR_W-1:0] IRQ_VECTOR = 8'hF0;
  localparam int F_CARRY = 0;
  localparam int F_ZERO  = 1;

  typedef enum logic [OP_W-1:0] {
    OP_NONE = 3'd0,
    OP_JMP  = 3'd1,
    OP_JC   = 3'd2,
    OP_JNC  = 3'd3,
    OP_JZ   = 3'd4,
    OP_JNZ  = 3'd5,
    OP_RET  = 3'd6
  } jump_op_e;
endpackage

// File: rtl/jic_cond_eval.sv
module jic_cond_eval
  import jic_pkg::*;
(
  input  logic [OP_W-1:0]   op_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic              take_o,
  output logic              ret_o
);
  always_comb begin
    take_o = 1'b0;
    ret_o  = 1'b0;
    unique case (op_i)
      OP_JMP:  take_o = 1'b1;
      OP_JC:   take_o = flags_i[F_CARRY];
      OP_JNC:  take_o = ~flags_i[F_CARRY];
      OP_JZ:   take_o = flags_i[F_ZERO];
      OP_JNZ:  take_o = ~flags_i[F_ZERO];
      OP_RET:  ret_o  = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/jic_ctx_store.sv
module jic_ctx_store
  import jic_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              irq_i,
  input  logic              ret_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic              accept_o,
  output logic              busy_o,
  output logic [ADDR_W-1:0] saved_pc_o,
  output logic [FLAG_W-1:0] saved_flags_o
);
  assign accept_o = irq_i & ~busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o        <= 1'b0;
      saved_pc_o    <= '0;
      saved_flags_o <= '0;
    end else if (accept_o) begin
      busy_o        <= 1'b1;
      saved_pc_o    <= pc_i;
      saved_flags_o <= flags_i;
    end else if (ret_i) begin
      busy_o <= 1'b0;
    end
  end

  p_ctx_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !ret_i |=> busy_o && $stable(saved_pc_o) && $stable(saved_flags_o));
  p_capture_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i && !busy_o |=> busy_o && saved_pc_o == $past(pc_i) && saved_flags_o == $past(flags_i));
  p_ret_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_i && !accept_o |=> !busy_o);
endmodule

// File: rtl/jic_target_sel.sv
module jic_target_sel
  import jic_pkg::*;
(
  input  logic              accept_i,
  input  logic              take_i,
  input  logic              ret_i,
  input  logic [ADDR_W-1:0] target_i,
  input  logic [ADDR_W-1:0] saved_pc_i,
  output logic              redirect_o,
  output logic [ADDR_W-1:0] loc_o
);
  always_comb begin
    if (accept_i)    loc_o = IRQ_VECTOR;
    else if (ret_i)  loc_o = saved_pc_i;
    else             loc_o = target_i;
    redirect_o = accept_i | take_i | ret_i;
  end
endmodule

// File: rtl/jump_irq_ctrl.sv
module jump_irq_ctrl
  import jic_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OP_W-1:0]   jump_op_i,
  input  logic [ADDR_W-1:0] jump_target_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic              irq_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic              redirect_o,
  output logic [ADDR_W-1:0] jump_loc_o,
  output logic              restore_o,
  output logic [FLAG_W-1:0] flags_restored_o
);
  logic take, ret, accept, busy;
  logic [ADDR_W-1:0] saved_pc;
  logic [FLAG_W-1:0] saved_flags;

  jic_cond_eval i_cond (
    .op_i(jump_op_i), .flags_i(flags_i), .take_o(take), .ret_o(ret)
  );

  jic_ctx_store i_ctx (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_i(irq_i), .ret_i(ret),
    .pc_i(pc_i), .flags_i(flags_i), .accept_o(accept), .busy_o(busy),
    .saved_pc_o(saved_pc), .saved_flags_o(saved_flags)
  );

  jic_target_sel i_sel (
    .accept_i(accept), .take_i(take), .ret_i(ret), .target_i(jump_target_i),
    .saved_pc_i(saved_pc), .redirect_o(redirect_o), .loc_o(jump_loc_o)
  );

  assign restore_o        = ret & ~accept;
  assign flags_restored_o = saved_flags;

  p_irq_vector_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i && !busy |-> redirect_o && jump_loc_o == IRQ_VECTOR);
  p_none_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jump_op_i == OP_NONE && !accept |-> !redirect_o);
  p_jc_fail_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jump_op_i == OP_JC && !flags_i[F_CARRY] && !accept |-> !redirect_o);
  p_ret_target_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_o |-> redirect_o && jump_loc_o == saved_pc);
endmodule

// File: tb/test_jump_irq_ctrl.sv
module test_jump_irq_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] op = 3'd0;
  logic [7:0] tgt = 8'h00, pc = 8'h00;
  logic [3:0] flg = 4'h0;
  logic irq = 1'b0;
  logic red, rst_o;
  logic [7:0] loc;
  logic [3:0] rflg;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  jump_irq_ctrl i_jump_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .jump_op_i(op), .jump_target_i(tgt),
    .flags_i(flg), .irq_i(irq), .pc_i(pc), .redirect_o(red), .jump_loc_o(loc),
    .restore_o(rst_o), .flags_restored_o(rflg)
  );

  localparam int NV = 12;
  localparam logic [2:0] V_OP  [NV] = '{3'd0, 3'd2, 3'd2, 3'd3, 3'd3, 3'd4,
                                        3'd4, 3'd5, 3'd5, 3'd1, 3'd2, 3'd4};
  localparam logic [3:0] V_FLG [NV] = '{4'hF, 4'h1, 4'h0, 4'h0, 4'h1, 4'h2,
                                        4'hD, 4'hD, 4'h2, 4'h0, 4'hE, 4'hF};
  localparam logic [7:0] V_TGT [NV] = '{8'h33, 8'h10, 8'h11, 8'h22, 8'h23, 8'h40,
                                        8'h41, 8'h5A, 8'h5B, 8'hA5, 8'h77, 8'hC3};
  localparam logic       V_RED [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1,
                                        1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] o, input logic [7:0] t, input logic [3:0] f,
                       input logic [7:0] p, input logic i);
    @(negedge clk);
    op = o; tgt = t; flg = f; pc = p; irq = i;
    #1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    // R8: return straight after reset sees cleared context
    drive(3'd6, 8'h99, 4'h0, 8'h05, 1'b0);
    chk("R8 loc", loc, 8'h00);
    chk("R8 flags", {4'h0, rflg}, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    // table walk: R1, R2, R3
    for (int k = 0; k < NV; k++) begin
      drive(V_OP[k], V_TGT[k], V_FLG[k], 8'h08, 1'b0);
      chk("R1/R2/R3 redirect", {7'd0, red}, {7'd0, V_RED[k]});
      if (V_RED[k]) chk("R1/R3 loc", loc, V_TGT[k]);
    end
    // R4: interrupt overrides unconditional jump
    drive(3'd1, 8'h44, 4'hA, 8'h37, 1'b1);
    chk("R4 redirect", {7'd0, red}, 8'd1);
    chk("R4 loc", loc, 8'hF0);
    chk("R4 restore", {7'd0, rst_o}, 8'd0);
    // R6: second interrupt ignored while in service
    drive(3'd0, 8'h00, 4'h5, 8'hF0, 1'b1);
    chk("R6 no redirect", {7'd0, red}, 8'd0);
    drive(3'd1, 8'h50, 4'h5, 8'hF1, 1'b1);
    chk("R6 follows op", loc, 8'h50);
    // R5/R7: return restores first context
    drive(3'd6, 8'h00, 4'h0, 8'hF2, 1'b0);
    chk("R7 redirect", {7'd0, red}, 8'd1);
    chk("R5 loc", loc, 8'h37);
    chk("R5 flags", {4'h0, rflg}, 8'h0A);
    chk("R7 restore", {7'd0, rst_o}, 8'd1);
    // R7: service ended, new interrupt accepted
    drive(3'd0, 8'h00, 4'h3, 8'h12, 1'b1);
    chk("R7 reaccept", loc, 8'hF0);
    drive(3'd6, 8'h00, 4'h0, 8'hF0, 1'b0);
    chk("R5 new loc", loc, 8'h12);
    chk("R5 new flags", {4'h0, rflg}, 8'h03);
    // R8: reset mid-service
    drive(3'd0, 8'h00, 4'h9, 8'h66, 1'b1);
    @(negedge clk); rst_n = 1'b0;
    drive(3'd6, 8'h00, 4'h0, 8'h01, 1'b0);
    chk("R8 loc", loc, 8'h00);
    chk("R8 flags", {4'h0, rflg}, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    drive(3'd0, 8'h00, 4'h1, 8'h21, 1'b1);
    chk("R8 idle accept", loc, 8'hF0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule